// File: doc/BRIEF.md
# LAPD Two-Byte Address Recognizer

This block inspects the address field at the head of each received D-channel frame. The field is two octets long. It decides whether the frame is meant for this terminal before any payload moves on. The upstream deframer has already removed flags and stuffing. It presents octets with a valid strobe, marks the start of each frame with a pulse, and marks the end of the frame with a second pulse.

The service access point identifier in the first octet is compared with two programmable values and with the fixed group value. The command/response bit plays no part in that comparison. The terminal endpoint identifier in the second octet is compared with two programmable values and with the fixed broadcast value. Both extension bits must follow the address-field convention. The block reports which entries hit, together with a held accept or reject verdict. A transparent mode, selected by dropping the check enable, lets every complete address through.

Top module: `lapd_addr_filter`

## Requirements
- R1: After reset, accept, reject, sapi_hit and tei_hit are all zero.
- R2: The first address octet holds the SAPI in bits 7:2, the C/R bit in bit 1 and an extension bit in bit 0. The sapi_hit bits are: bit 0 for equal to sapi_a, bit 1 for equal to sapi_b, and bit 2 for equal to the group value 6'h3F (raw octet 0xFC or 0xFE). The C/R bit never changes any hit.
- R3: The second address octet holds the TEI in bits 7:1 and an extension bit in bit 0. The tei_hit bits are: bit 0 for equal to tei_a, bit 1 for equal to tei_b, and bit 2 for equal to the broadcast value 7'h7F (raw octet 0xFF).
- R4: With chk_en high, accept is set only when all of these hold: the first octet's bit 0 is 0, the second octet's bit 0 is 1, at least one sapi_hit bit is set, and at least one tei_hit bit is set. In every other case reject is set. accept and reject are never high together.
- R5: The verdict and the hit vectors appear in the clock cycle that follows the edge at which the second address octet is valid.
- R6: Once given, the verdict and the hit vectors hold until the next sof. Further octets and frame_end pulses do not change them.
- R7: If frame_end arrives before a second octet does, reject is set and the hit vectors stay zero. This is true whatever chk_en is. It also covers a frame_end that arrives in the same cycle as the first octet.
- R8: With chk_en low, any frame with two address octets is accepted. The hit vectors are still reported.
- R9: sof clears the verdict and the hit vectors. An octet that is valid in the same cycle as sof counts as the frame's first octet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start-of-frame pulse |
| byte_vld | input | 1 | Octet valid strobe |
| byte_in | input | 8 | Received octet |
| frame_end | input | 1 | End-of-frame pulse |
| chk_en | input | 1 | Address check enable (low = transparent) |
| sapi_a | input | 6 | First programmable SAPI |
| sapi_b | input | 6 | Second programmable SAPI |
| tei_a | input | 7 | First programmable TEI |
| tei_b | input | 7 | Second programmable TEI |
| accept | output | 1 | Frame accepted, held until next sof |
| reject | output | 1 | Frame rejected, held until next sof |
| sapi_hit | output | 3 | SAPI entries that matched |
| tei_hit | output | 3 | TEI entries that matched |

## Verification
All 256 first octets are swept against one valid second octet, and all 256 second octets are swept against one valid first octet. These two sweeps separate the SAPI entries from the group value, show that the C/R bit is ignored, and show that each extension bit is enforced on its own octet. The same sweeps run again with chk_en low, which separates the transparent verdict from the hit reporting. Short frames, including one where the frame end coincides with the first octet, are checked against complete frames. Octets sent after a verdict, and a lone sof, show that the verdict holds and then clears.

// File: rtl/lapd_addr_filter.sv
module lapd_addr_filter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       frame_end,
  input  logic       chk_en,
  input  logic [5:0] sapi_a,
  input  logic [5:0] sapi_b,
  input  logic [6:0] tei_a,
  input  logic [6:0] tei_b,
  output logic       accept,
  output logic       reject,
  output logic [2:0] sapi_hit,
  output logic [2:0] tei_hit
);
  localparam logic [5:0] SAPI_GROUP = 6'h3F;
  localparam logic [6:0] TEI_BCAST  = 7'h7F;

  logic [7:0] first_q;
  logic       got_first, done;

  wire eff_first = got_first & ~sof;
  wire eff_done  = done & ~sof;

  wire [5:0] sapi = first_q[7:2];
  wire [6:0] tei  = byte_in[7:1];

  wire [2:0] s_hit = {sapi == SAPI_GROUP, sapi == sapi_b, sapi == sapi_a};
  wire [2:0] t_hit = {tei == TEI_BCAST, tei == tei_b, tei == tei_a};

  wire addr_ok = ~first_q[0] & byte_in[0] & (|s_hit) & (|t_hit);
  wire pass    = ~chk_en | addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q   <= '0;
      got_first <= 1'b0;
      done      <= 1'b0;
      accept    <= 1'b0;
      reject    <= 1'b0;
      sapi_hit  <= '0;
      tei_hit   <= '0;
    end else begin
      if (sof) begin
        got_first <= 1'b0;
        done      <= 1'b0;
        accept    <= 1'b0;
        reject    <= 1'b0;
        sapi_hit  <= '0;
        tei_hit   <= '0;
      end
      if (!eff_done) begin
        if (byte_vld && !eff_first) begin
          first_q   <= byte_in;
          got_first <= 1'b1;
          if (frame_end) begin
            reject <= 1'b1;
            done   <= 1'b1;
          end
        end else if (byte_vld) begin
          accept   <= pass;
          reject   <= ~pass;
          sapi_hit <= s_hit;
          tei_hit  <= t_hit;
          done     <= 1'b1;
        end else if (frame_end) begin
          reject <= 1'b1;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lapd_addr_filter_chk.sv
module lapd_addr_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sof,
  input logic       byte_vld,
  input logic       chk_en,
  input logic       accept,
  input logic       reject,
  input logic [2:0] sapi_hit,
  input logic [2:0] tei_hit
);
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && reject)); // R4

  AST_ACCEPT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sof) |=> accept); // R6

  AST_REJECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !sof) |=> reject); // R6

  AST_HITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((accept || reject) && !sof) |=> $stable(sapi_hit) && $stable(tei_hit)); // R6

  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !byte_vld) |=> !accept && !reject && sapi_hit == 3'b0 && tei_hit == 3'b0); // R9

  AST_ACCEPT_ON_OCTET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept) |-> $past(byte_vld)); // R5

  AST_ACCEPT_NEEDS_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(accept) && $past(chk_en)) |-> (|sapi_hit) && (|tei_hit)); // R4
endmodule

bind lapd_addr_filter lapd_addr_filter_chk u_chk (.*);

// File: tb/sim_lapd_addr_filter.sv
module sim_lapd_addr_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 1'b0, byte_vld = 1'b0, frame_end = 1'b0, chk_en = 1'b1;
  logic [7:0] byte_in = '0;
  logic [5:0] sapi_a = 6'h05, sapi_b = 6'h2A;
  logic [6:0] tei_a = 7'h10, tei_b = 7'h40;
  logic accept, reject;
  logic [2:0] sapi_hit, tei_hit;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lapd_addr_filter u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] b1, input logic [7:0] b2, input logic en);
    logic [2:0] s, t;
    logic ok;
    s = {b1[7:2] == 6'h3F, b1[7:2] == sapi_b, b1[7:2] == sapi_a};
    t = {b2[7:1] == 7'h7F, b2[7:1] == tei_b, b2[7:1] == tei_a};
    ok = !en || (!b1[0] && b2[0] && (|s) && (|t));
    return {ok, !ok, s, t};
  endfunction

  function automatic logic [7:0] outs();
    return {accept, reject, sapi_hit, tei_hit};
  endfunction

  task automatic frame(input logic [7:0] b1, input logic [7:0] b2);
    @(negedge clk); sof = 1; byte_vld = 1; byte_in = b1;
    @(negedge clk); sof = 0; byte_in = b2;
    @(negedge clk); byte_vld = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", outs(), 8'h00);
    rst_n = 1;

    for (int en = 1; en >= 0; en--) begin
      chk_en = en[0];
      for (int b = 0; b < 256; b++) begin
        frame(b[7:0], {tei_a, 1'b1});
        chk(en ? "R2 R4 R5 sapi sweep" : "R8 sapi sweep", outs(), model(b[7:0], {tei_a, 1'b1}, en[0]));
      end
      for (int b = 0; b < 256; b++) begin
        frame({sapi_b, 2'b10}, b[7:0]);
        chk(en ? "R3 R4 R5 tei sweep" : "R8 tei sweep", outs(), model({sapi_b, 2'b10}, b[7:0], en[0]));
      end
    end
    chk_en = 1;

    // R2: the C/R bit alone must not change the result
    frame(8'hFC, 8'hFF); chk("R2 group cr0", outs(), 8'b10_100_100);
    frame(8'hFE, 8'hFF); chk("R2 group cr1", outs(), 8'b10_100_100);

    // R6: later octets and frame_end leave the verdict alone
    frame({sapi_a, 2'b00}, {tei_b, 1'b1});
    @(negedge clk); byte_vld = 1; byte_in = 8'h01;
    @(negedge clk); byte_in = 8'hFF; frame_end = 1;
    @(negedge clk); byte_vld = 0; frame_end = 0;
    chk("R6 hold accept", outs(), 8'b10_001_010);
    frame(8'h01, {tei_a, 1'b1});
    @(negedge clk); byte_vld = 1; byte_in = {sapi_a, 2'b00};
    @(negedge clk); byte_vld = 0;
    chk("R6 hold reject", outs(), {2'b01, 3'b000, 3'b001});

    // R9: a lone sof clears
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0;
    chk("R9 sof clears", outs(), 8'h00);

    // R7: short frames
    for (int en = 0; en < 2; en++) begin
      chk_en = en[0];
      @(negedge clk); sof = 1; byte_vld = 1; byte_in = {sapi_a, 2'b00};
      @(negedge clk); sof = 0; byte_vld = 0; frame_end = 1;
      @(negedge clk); frame_end = 0;
      chk("R7 short frame", outs(), 8'b01_000_000);
      @(negedge clk); sof = 1; byte_vld = 1; frame_end = 1; byte_in = {sapi_a, 2'b00};
      @(negedge clk); sof = 0; byte_vld = 0; frame_end = 0;
      chk("R7 end with first octet", outs(), 8'b01_000_000);
      @(negedge clk); sof = 1;
      @(negedge clk); sof = 0; frame_end = 1;
      @(negedge clk); frame_end = 0;
      chk("R7 empty frame", outs(), 8'b01_000_000);
    end
    chk_en = 1;

    // R5: nothing before the second octet's edge
    @(negedge clk); sof = 1; byte_vld = 1; byte_in = {sapi_a, 2'b00};
    @(negedge clk); sof = 0; byte_in = {tei_a, 1'b1};
    chk("R5 no early verdict", outs(), 8'h00);
    @(negedge clk); byte_vld = 0;
    chk("R5 verdict next cycle", outs(), 8'b10_001_001);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule